// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block stores frames arriving from a MAC as a byte stream into a circular buffer in memory. Each frame is written as one record. The record is a 32-bit header word followed by the frame bytes, including the 4-byte frame check sequence. Every record starts on a word boundary, and addresses wrap at the end of the ring, so a record may run past the top of the ring and continue at offset 0. Memory is written through a word-wide port with per-byte enables.

The host consumes records and reports how far it has read by writing a read-pointer register. That register is kept 16 bytes behind the true consume position, so the block adds 16 to find where unread data starts. A header holds a placeholder length of 0xFFF0 until the last data word of its frame is in memory, so software never parses a frame that is still arriving. A frame is dropped by rewinding to its header slot, which leaves the write pointer unchanged. This happens when the MAC flags the frame as bad at its end. It also happens when storing the frame would run into unread data, and in that case a missed-frame counter is incremented.

The control is a five-state machine:
- ARM writes the placeholder header at the write pointer and always moves to IDLE.
- IDLE waits for the first byte.
- FILL packs bytes into words.
- COMMIT writes the final header, advances the write pointer and returns to ARM.
- DROP swallows the rest of an overrun frame and returns to ARM on its last byte.

From IDLE or FILL, an accepted byte leads to one of these states:
- ARM, for a bad end of frame, or for an overrun on the frame's last byte.
- DROP, for an overrun on any other byte.
- COMMIT, for a clean last byte.
- FILL, for any other byte.

The source must leave at least two idle cycles between frames, to cover the COMMIT and ARM cycles.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, wr_ptr is 0, host_rd reads 0xFFF0, rx_empty is 1 and missed is 0. The first memory write after reset is the placeholder header at word 0.
- R2: A stored frame's header has the byte count of the frame, FCS included, in bits 31:16. Bit 0 is the receive-OK flag and is set to 1. Bits 15:1 are 0.
- R3: The header slot holds 0xFFF00000 (length field 0xFFF0) for the whole time its frame is being written. The final header is written only after the frame's last data word.
- R4: Frame byte k is stored at byte offset header+4+k, modulo the ring size. Byte offset 4w+b sits in lane b of memory word w, which is bits 8b+7:8b. The enabled lanes of a write are always contiguous from lane 0.
- R5: The next record starts at header + 4 + the frame length rounded up to a multiple of 4. wr_ptr reports that byte offset.
- R6: All record addresses wrap modulo the ring size of 2^RING_LOG2 bytes. A frame may straddle the end of the ring.
- R7: host_rd reads back the value the host last wrote. The true read position is (host_rd + 16) modulo the ring size.
- R8: rx_empty is 1 exactly when the true read position equals wr_ptr.
- R9: A frame is dropped if any of its data words would be written at the read word or at the word just before it. The drop increments missed by one and leaves wr_ptr unchanged.
- R10: A frame that ends with in_err set alongside in_last is discarded. wr_ptr and missed are left unchanged.
- R11: After a dropped or discarded frame, the next frame is stored at the same header slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | This byte ends the frame |
| in_err | input | 1 | Frame is bad; sampled with in_last |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | RING_LOG2-2 | Word address within the ring |
| mem_be | output | 4 | Byte-lane enables for the write |
| mem_wdata | output | 32 | Write data, byte lane b in bits 8b+7:8b |
| host_rd_we | input | 1 | Host writes the read-pointer register |
| host_rd_wdata | input | 16 | New read-pointer value (biased by -16) |
| host_rd | output | 16 | Current read-pointer register |
| wr_ptr | output | 16 | Byte offset of the next record header |
| rx_empty | output | 1 | No unread record in the ring |
| missed | output | CNT_W | Frames dropped for lack of space |

## Verification
The bench sends frames of several lengths, and each kind of frame separates a different failure:
- Lengths that are multiples of four and lengths that are not show whether padding and the rounding of the next header are right.
- A frame that crosses the top of the ring shows whether the wrap is applied per word.
- A single-byte frame covers the case where the first byte is also the last.
- A frame ended with the error flag, and a frame too long for the free space, tell the two drop paths apart: only the second may move the missed counter, and neither may move the write pointer.

The host pointer is written both to empty the ring and to limit the free space, which checks the 16-byte bias. A reference model advances its pointers and counters cycle by cycle and is compared on every clock.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        S_ARM    = 3'd0,
        S_IDLE   = 3'd1,
        S_FILL   = 3'd2,
        S_COMMIT = 3'd3,
        S_DROP   = 3'd4
    } rxr_state_e;

    // Header written while a frame is still being copied
    localparam logic [31:0] HDR_PENDING = 32'hFFF0_0000;
    // Status half of a completed header: receive-OK in bit 0
    localparam logic [15:0] STAT_OK     = 16'h0001;
    // Host pointer lags the real consume position by this many bytes
    localparam logic [15:0] RD_BIAS     = 16'd16;

endpackage

// File: rtl/rxr_rdptr.sv
module rxr_rdptr
    import rxr_pkg::*;
#(
    parameter int RING_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [15:0]          host_wdata,
    input  logic [RING_LOG2-3:0] commit_word,
    output logic [15:0]          host_q,
    output logic [RING_LOG2-3:0] rd_word,
    output logic                 empty
);
    localparam int WW = RING_LOG2 - 2;
    localparam logic [WW-1:0] BIAS_WORDS = WW'(RD_BIAS >> 2);
    localparam logic [15:0]   RD_RESET   = 16'h0000 - RD_BIAS;

    always_ff @(posedge clk) begin
        if (!rst_n)       host_q <= RD_RESET;
        else if (host_we) host_q <= host_wdata;
    end

    // True read word = biased register plus the bias, wrapped to the ring
    assign rd_word = host_q[RING_LOG2-1:2] + BIAS_WORDS;
    assign empty   = (rd_word == commit_word);

endmodule

// File: rtl/rxr_lane_pack.sv
module rxr_lane_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        push,
    input  logic        flush,
    input  logic [7:0]  din,
    output logic [1:0]  lane,
    output logic [31:0] word,
    output logic [3:0]  be
);
    logic [1:0] lane_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) lane_q <= 2'd0;
        else if (push)     lane_q <= flush ? 2'd0 : lane_q + 2'd1;
    end

    for (genvar b = 0; b < 4; b++) begin : g_lane
        if (b < 3) begin : g_store
            logic [7:0] hold_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                         hold_q <= 8'h00;
                else if (push && lane_q == 2'(b))   hold_q <= din;
            end
            assign word[8*b +: 8] = (lane_q > 2'(b))  ? hold_q :
                                    (lane_q == 2'(b)) ? din : 8'h00;
        end else begin : g_top
            assign word[8*b +: 8] = (lane_q == 2'(b)) ? din : 8'h00;
        end
        assign be[b] = (lane_q >= 2'(b));
    end

    assign lane = lane_q;

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int RING_LOG2 = 8,
    parameter int CNT_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_last,
    input  logic                 in_err,
    output logic                 mem_we,
    output logic [RING_LOG2-3:0] mem_addr,
    output logic [3:0]           mem_be,
    output logic [31:0]          mem_wdata,
    input  logic                 host_rd_we,
    input  logic [15:0]          host_rd_wdata,
    output logic [15:0]          host_rd,
    output logic [15:0]          wr_ptr,
    output logic                 rx_empty,
    output logic [CNT_W-1:0]     missed
);
    localparam int WW = RING_LOG2 - 2;

    rxr_state_e    state_q, state_d;
    logic [WW-1:0] commit_q, wa_q, wa_inc, rd_word;
    logic [15:0]   len_q;
    logic [CNT_W-1:0] missed_q;
    logic [1:0]    lane;
    logic [31:0]   pack_word;
    logic [3:0]    pack_be;
    logic          take, word_done, bad_end, near_rd, overrun;

    assign take      = in_valid && (state_q == S_IDLE || state_q == S_FILL);
    assign word_done = take && (lane == 2'd3 || in_last);
    assign bad_end   = take && in_last && in_err;
    assign wa_inc    = wa_q + 1'b1;
    // One-word guard keeps a full ring distinguishable from an empty one
    assign near_rd   = (wa_q == rd_word) || (wa_inc == rd_word);
    assign overrun   = word_done && !bad_end && near_rd;

    rxr_rdptr #(.RING_LOG2(RING_LOG2)) u_rdptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_rd_we),
        .host_wdata  (host_rd_wdata),
        .commit_word (commit_q),
        .host_q      (host_rd),
        .rd_word     (rd_word),
        .empty       (rx_empty)
    );

    rxr_lane_pack u_pack (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == S_ARM),
        .push  (take),
        .flush (word_done),
        .din   (in_data),
        .lane  (lane),
        .word  (pack_word),
        .be    (pack_be)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_ARM;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ARM:    state_d = S_IDLE;
            S_IDLE, S_FILL: begin
                if (take) begin
                    if (bad_end)                  state_d = S_ARM;
                    else if (overrun)             state_d = in_last ? S_ARM : S_DROP;
                    else if (word_done && in_last) state_d = S_COMMIT;
                    else                          state_d = S_FILL;
                end
            end
            S_COMMIT: state_d = S_ARM;
            S_DROP:   if (in_valid && in_last) state_d = S_ARM;
            default:  state_d = S_ARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q  <= '0;
            wa_q      <= '0;
            len_q     <= '0;
            missed_q  <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_be    <= 4'h0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            unique case (state_q)
                S_ARM: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= commit_q;
                    mem_be    <= 4'hF;
                    mem_wdata <= HDR_PENDING;
                    wa_q      <= commit_q + 1'b1;
                    len_q     <= '0;
                end
                S_IDLE, S_FILL: begin
                    if (take && !bad_end) begin
                        len_q <= len_q + 1'b1;
                        if (overrun) begin
                            missed_q <= missed_q + 1'b1;
                        end else if (word_done) begin
                            mem_we    <= 1'b1;
                            mem_addr  <= wa_q;
                            mem_be    <= pack_be;
                            mem_wdata <= pack_word;
                            wa_q      <= wa_inc;
                        end
                    end
                end
                S_COMMIT: begin
                    mem_we    <= 1'b1;
                    mem_addr  <= commit_q;
                    mem_be    <= 4'hF;
                    mem_wdata <= {len_q, STAT_OK};
                    commit_q  <= wa_q;
                end
                default: ;
            endcase
        end
    end

    assign wr_ptr = 16'({commit_q, 2'b00});
    assign missed = missed_q;

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk
    import rxr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input rxr_state_e       state,
    input logic             in_valid,
    input logic             in_last,
    input logic             in_err,
    input logic             mem_we,
    input logic [3:0]       mem_be,
    input logic [31:0]      mem_wdata,
    input logic [15:0]      wr_ptr,
    input logic             rx_empty,
    input logic [CNT_W-1:0] missed
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rx_empty && missed == '0 && wr_ptr == 16'h0));

    p_pending_header_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ARM) |=> (mem_we && mem_be == 4'hF && mem_wdata == HDR_PENDING));

    p_final_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT) |=> (mem_we && mem_wdata[15:0] == STAT_OK &&
                                 mem_wdata[31:16] != 16'hFFF0 && mem_wdata[31:16] != 16'h0));

    p_lanes_contiguous_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

    p_commit_not_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT) |=> !rx_empty);

    p_missed_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (missed != $past(missed)) |-> (missed == $past(missed) + 1'b1));

    p_bad_end_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_IDLE || state == S_FILL) && in_valid && in_last && in_err)
        |=> (state == S_ARM && $stable(wr_ptr) && $stable(missed)));

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state_q),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_err    (in_err),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .wr_ptr    (wr_ptr),
    .rx_empty  (rx_empty),
    .missed    (missed)
);

// File: tb/tb_rx_ring_writer.sv
`timescale 1ns/1ps
module tb_rx_ring_writer;

    localparam int RB = 256;
    localparam int DW = RB / 4;
    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        host_rd_we = 1'b0;
    logic [15:0] host_rd_wdata = 16'h0;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [15:0] host_rd, wr_ptr;
    logic        rx_empty;
    logic [15:0] missed;

    int n_chk = 0, n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    int m_commit = 0, m_rp = 0, m_missed = 0;
    logic [15:0] m_host = 16'hFFF0;
    logic [7:0] bmem [RB];

    always #(CLK_NS/2) clk = ~clk;

    rx_ring_writer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .host_rd_we(host_rd_we),
        .host_rd_wdata(host_rd_wdata), .host_rd(host_rd), .wr_ptr(wr_ptr),
        .rx_empty(rx_empty), .missed(missed)
    );

    initial for (int i = 0; i < RB; i++) bmem[i] = 8'hEE;

    // Memory image built only from what the port writes
    always @(negedge clk) begin
        if (mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) bmem[int'(mem_addr) * 4 + b] = mem_wdata[8*b +: 8];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bword(input int w);
        int base = (w % DW) * 4;
        return {bmem[base+3], bmem[base+2], bmem[base+1], bmem[base]};
    endfunction

    function automatic logic [7:0] pat(input int tag, input int k);
        return 8'(tag * 37 + k * 7 + 3);
    endfunction

    // Per-cycle comparison with the reference model
    always @(posedge clk) begin
        if (mon_en) begin
            #5;
            chk("R6 wr_ptr per cycle", 32'(wr_ptr), 32'(m_commit * 4));
            chk("R8 empty per cycle", 32'(rx_empty), 32'(m_rp == m_commit));
            chk("R9 missed per cycle", 32'(missed), 32'(m_missed));
            chk("R7 host pointer per cycle", 32'(host_rd), 32'(m_host));
        end
    end

    task automatic host_write(input logic [15:0] v);
        @(negedge clk);
        host_rd_we = 1'b1;
        host_rd_wdata = v;
        m_host = v;
        m_rp = ((int'(v) + 16) % RB) / 4;
        @(negedge clk);
        host_rd_we = 1'b0;
    endtask

    task automatic send_frame(input int len, input bit err, input int tag);
        int hdr = m_commit;
        int nw = (len + 3) / 4;
        bit dropping = 1'b0;
        int nbad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = pat(tag, i);
            in_last  = (i == len - 1);
            in_err   = err && (i == len - 1);
            if ((i % 4 == 3) || (i == len - 1)) begin
                int a = (hdr + 1 + i / 4) % DW;
                if (!dropping && !(err && i == len - 1) &&
                    (a == m_rp || (a + 1) % DW == m_rp)) begin
                    dropping = 1'b1;
                    m_missed++;
                end
            end
            if (i == 1) chk("R3 placeholder while arriving", bword(hdr), 32'hFFF0_0000);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
        if (!dropping && !err) begin
            chk("R3 header withheld until last word", bword(hdr), 32'hFFF0_0000);
            m_commit = (hdr + 1 + nw) % DW;
        end
        repeat (3) @(negedge clk);
        if (!dropping && !err) begin
            chk("R2 final header", bword(hdr), {16'(len), 16'h0001});
            for (int k = 0; k < len; k++)
                if (bmem[(hdr * 4 + 4 + k) % RB] !== pat(tag, k)) nbad++;
            chk("R4 payload bytes mismatching", 32'(nbad), 32'd0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk("R1 wr_ptr after reset", 32'(wr_ptr), 32'd0);
        chk("R1 host_rd after reset", 32'(host_rd), 32'hFFF0);
        chk("R1 empty after reset", 32'(rx_empty), 32'd1);
        chk("R1 missed after reset", 32'(missed), 32'd0);
        repeat (2) @(negedge clk);
        chk("R1 placeholder at word 0", bword(0), 32'hFFF0_0000);

        send_frame(64, 1'b0, 1);
        chk("R5 next record after 64 bytes", 32'(wr_ptr), 32'd68);
        send_frame(61, 1'b0, 2);
        chk("R5 next record after 61 bytes rounded", 32'(wr_ptr), 32'd136);
        chk("R8 not empty with unread frames", 32'(rx_empty), 32'd0);

        host_write(16'd120);
        @(negedge clk);
        chk("R7 host pointer readback", 32'(host_rd), 32'd120);
        chk("R8 empty after host consumed all", 32'(rx_empty), 32'd1);

        send_frame(100, 1'b0, 3);
        send_frame(70, 1'b0, 4);
        chk("R6 wr_ptr after wrapping frame", 32'(wr_ptr), 32'd60);
        chk("R6 wrapped byte at offset 0", 32'(bmem[0]), 32'(pat(4, 12)));

        send_frame(20, 1'b1, 5);
        chk("R10 wr_ptr kept after bad frame", 32'(wr_ptr), 32'd60);
        chk("R10 missed kept after bad frame", 32'(missed), 32'd0);
        chk("R10 slot holds placeholder again", bword(15), 32'hFFF0_0000);

        send_frame(100, 1'b0, 6);
        chk("R9 missed after overrun", 32'(missed), 32'd1);
        chk("R9 wr_ptr kept after overrun", 32'(wr_ptr), 32'd60);

        host_write(16'd44);
        @(negedge clk);
        chk("R8 empty at biased pointer 44", 32'(rx_empty), 32'd1);

        send_frame(1, 1'b0, 7);
        chk("R11 frame stored at rewound slot", bword(15), {16'd1, 16'h0001});
        chk("R5 next record after 1 byte", 32'(wr_ptr), 32'd68);
        chk("R8 not empty after one-byte frame", 32'(rx_empty), 32'd0);

        send_frame(63, 1'b0, 8);
        chk("R5 next record after 63 bytes", 32'(wr_ptr), 32'd136);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule